// File: doc/BRIEF.md
# Snapshot-Read Free-Running Counter

This block keeps a counter twice the bus width (64 bits at the default 32-bit bus) that advances by one on every clock and is never read live. Software works through three registers on a single-cycle register bus: a command register and two holding registers that carry the lower and upper halves of a captured count. Setting the capture bit in the command register copies the whole counter into both holding registers on one clock edge. Setting the zero bit restarts the counter from zero and empties both holding registers.

A command written in one cycle is carried out on the following clock edge. The command bit reads back as one in the cycle right after the write and then drops to zero by itself. The holding registers can also be written directly, for example to preset a known value. Reads are registered: the data for a read request shows on the read port after the next clock edge and stays there until the next read.

Top module: `snapcnt_top`

## Requirements
- R1: After synchronous reset the counter, the command bits, both holding registers and the read data port are zero, and reads of word addresses 0, 1 and 2 return zero.
- R2: The counter advances by exactly one per clock while no zero command is carried out, and it wraps from all ones to zero.
- R3: A write to word address 0 with bit 1 set (capture) stores, on the next clock edge, the full counter value into both holding registers at once: bits DATA_W-1:0 at word address 1 and the upper half at word address 2. After a zero command carried out with j idle cycles between the zero write and the capture write, the captured value is j.
- R4: The command bits read at word address 0 (bit 0 zero, bit 1 capture) show as one for a read issued in the cycle right after the command write, and as zero for any later read when no new command is written.
- R5: A write to word address 0 with bit 0 set (zero) clears both holding registers and restarts the counter from zero on the next clock edge.
- R6: When bits 0 and 1 are written together, the zero command wins: both holding registers read zero and the counter restarts.
- R7: The holding registers at word addresses 1 and 2 accept direct writes and read back the written value; without a write or command they keep their value.
- R8: A direct write to a holding register that falls on the same clock edge as a command being carried out is dropped; the command result is kept.
- R9: The capture never tears across the carry between halves: at counts 255 and 256 of a 16-bit counter the halves read 0xFF/0x00 and 0x00/0x01.
- R10: Word address 3 reads as zero and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid after the edge that takes the read |

## Verification
A command is carried out one edge after its write, so the edge that captures or zeroes can coincide with a direct write to a holding register; the bench provokes this by issuing a holding-register write immediately after a command write, and judges it by reading the register back and expecting the command result (the captured count or zero), never the written data. The zero and capture commands can also be carried out together, provoked by writing both bits at once, and judged by zero holding registers followed by a capture whose value proves the counter restarted on that same edge.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  // word addresses of the register map
  localparam int A_CTRL = 0;
  localparam int A_LO   = 1;
  localparam int A_HI   = 2;
  // command bit positions in the control word
  localparam int BIT_CLR   = 0;
  localparam int BIT_LATCH = 1;

  // pending command, packed so bit positions match the control word
  typedef struct packed {
    logic latch;
    logic clr;
  } cmd_t;
endpackage

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || zero) count <= '0;
    else             count <= count + 1'b1;
  end
endmodule

// File: rtl/snapcnt_cmd.sv
module snapcnt_cmd
  import snapcnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_ctrl,
  input  cmd_t cmd_in,
  output cmd_t cmd_q
);
  // a written command is held for exactly one cycle, then drops
  always_ff @(posedge clk) begin
    if (rst)          cmd_q <= '0;
    else if (wr_ctrl) cmd_q <= cmd_in;
    else              cmd_q <= '0;
  end
endmodule

// File: rtl/snapcnt_hold.sv
module snapcnt_hold #(
  parameter int DATA_W = 32,
  parameter int NHALF  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NHALF*DATA_W-1:0] count,
  input  logic                    do_clr,
  input  logic                    do_latch,
  input  logic [NHALF-1:0]        wr_half,
  input  logic [DATA_W-1:0]       wdata,
  output logic [NHALF*DATA_W-1:0] snap
);
  logic [DATA_W-1:0] half_q [NHALF];

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    // command actions outrank direct writes on the same edge
    always_ff @(posedge clk) begin
      if (rst || do_clr)  half_q[g] <= '0;
      else if (do_latch)  half_q[g] <= count[g*DATA_W +: DATA_W];
      else if (wr_half[g]) half_q[g] <= wdata;
    end
    assign snap[g*DATA_W +: DATA_W] = half_q[g];
  end
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
  import snapcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NHALF = 2;
  localparam int CNT_W = NHALF * DATA_W;

  logic              wr_en, rd_en, wr_ctrl;
  logic [NHALF-1:0]  wr_half;
  cmd_t              cmd_in, cmd_q;
  logic              do_clr, do_latch;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  snap_q;
  logic [DATA_W-1:0] ctrl_view, rd_next;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign wr_ctrl = wr_en && (bus_addr == ADDR_W'(A_CTRL));

  for (genvar h = 0; h < NHALF; h++) begin : g_wsel
    assign wr_half[h] = wr_en && (bus_addr == ADDR_W'(A_LO + h));
  end

  assign cmd_in = '{latch: bus_wdata[BIT_LATCH], clr: bus_wdata[BIT_CLR]};

  snapcnt_cmd u_cmd (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .cmd_in  (cmd_in),
    .cmd_q   (cmd_q)
  );

  // zero wins over capture when both are pending
  assign do_clr   = cmd_q.clr;
  assign do_latch = cmd_q.latch & ~cmd_q.clr;

  snapcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .zero  (do_clr),
    .count (count_q)
  );

  snapcnt_hold #(.DATA_W(DATA_W), .NHALF(NHALF)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .count    (count_q),
    .do_clr   (do_clr),
    .do_latch (do_latch),
    .wr_half  (wr_half),
    .wdata    (bus_wdata),
    .snap     (snap_q)
  );

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[BIT_CLR]   = cmd_q.clr;
    ctrl_view[BIT_LATCH] = cmd_q.latch;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(A_CTRL): rd_next = ctrl_view;
      ADDR_W'(A_LO):   rd_next = snap_q[DATA_W-1:0];
      ADDR_W'(A_HI):   rd_next = snap_q[CNT_W-1:DATA_W];
      default:         rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/snapcnt_chk.sv
module snapcnt_chk
  import snapcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [2*DATA_W-1:0] count_q,
  input cmd_t                cmd_q,
  input logic [2*DATA_W-1:0] snap_q
);
  logic w_ctrl, w_half, r_unused;
  assign w_ctrl   = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign w_half   = bus_sel && bus_wr &&
                    ((bus_addr == ADDR_W'(A_LO)) || (bus_addr == ADDR_W'(A_HI)));
  assign r_unused = bus_sel && !bus_wr && (int'(bus_addr) > A_HI);

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (count_q == '0 && snap_q == '0 && cmd_q == '0 && bus_rdata == '0));

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    !cmd_q.clr |=> count_q == $past(count_q) + 1'b1);

  // R3 and R8: a capture lands even when a direct write shares the edge
  a_r3_capture_whole: assert property (@(posedge clk) disable iff (rst)
    (cmd_q.latch && !cmd_q.clr) |=> snap_q == $past(count_q));

  a_r4_cmd_selfclear: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != '0 && !w_ctrl) |=> cmd_q == '0);

  // R5 and R6: zero wins over capture
  a_r5_zero_all: assert property (@(posedge clk) disable iff (rst)
    cmd_q.clr |=> (count_q == '0 && snap_q == '0));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == '0 && !w_half) |=> $stable(snap_q));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    r_unused |=> bus_rdata == '0);
endmodule

bind snapcnt_top snapcnt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .count_q   (count_q),
  .cmd_q     (cmd_q),
  .snap_q    (snap_q)
);

// File: tb/snapcnt_top_test.sv
`timescale 1ns/1ps
module snapcnt_top_test;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  snapcnt_top #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // every bus task starts and ends at a falling edge, one cycle each
  task automatic wr(input int a, input int d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // zero, wait j idle cycles, capture; the captured count is j
  task automatic capture_after_zero(input int j, input string tag);
    int lo, hi;
    wr(0, 1);
    idle(j);
    wr(0, 2);
    idle(2);
    rd(1, lo);
    rd(2, hi);
    check({tag, " low"},  lo, j & 8'hFF);
    check({tag, " high"}, hi, (j >> 8) & 8'hFF);
  endtask

  task automatic t_reset();
    int d;
    check("R1 rdata after reset", int'(bus_rdata), 0);
    for (int a = 0; a < 3; a++) begin
      rd(a, d);
      check("R1 register after reset", d, 0);
    end
  endtask

  task automatic t_selfclear();
    int d;
    wr(0, 2);
    rd(0, d); check("R4 capture bit visible", d, 2);
    rd(0, d); check("R4 capture bit dropped", d, 0);
    wr(0, 1);
    rd(0, d); check("R4 zero bit visible", d, 1);
    rd(0, d); check("R4 zero bit dropped", d, 0);
  endtask

  task automatic t_capture();
    capture_after_zero(0,  "R3 back-to-back");
    capture_after_zero(5,  "R3 j=5");
    capture_after_zero(40, "R2 j=40");
  endtask

  task automatic t_carry();
    capture_after_zero(255, "R9 count 255");
    capture_after_zero(256, "R9 count 256");
    capture_after_zero(511, "R9 count 511");
  endtask

  task automatic t_wrap();
    int lo, hi;
    capture_after_zero(65535, "R2 all ones");
    // zero edge at E0; captures so far put the next capture at E0+65541
    wr(0, 2);
    idle(2);
    rd(1, lo); rd(2, hi);
    check("R2 wrapped low", lo, 4);
    check("R2 wrapped high", hi, 0);
  endtask

  task automatic t_direct();
    int d;
    wr(1, 8'h5A);
    wr(2, 8'hC3);
    idle(3);
    rd(1, d); check("R7 low readback", d, 8'h5A);
    rd(2, d); check("R7 high readback", d, 8'hC3);
    wr(3, 8'hFF);
    rd(3, d); check("R10 unused reads zero", d, 0);
    rd(1, d); check("R10 low untouched", d, 8'h5A);
    rd(2, d); check("R10 high untouched", d, 8'hC3);
    rd(0, d); check("R10 control untouched", d, 0);
  endtask

  task automatic t_zero();
    int d;
    wr(1, 8'h77); wr(2, 8'h66);
    wr(0, 1);
    idle(2);
    rd(1, d); check("R5 low zeroed", d, 0);
    rd(2, d); check("R5 high zeroed", d, 0);
  endtask

  task automatic t_both();
    int d;
    wr(1, 8'h11); wr(2, 8'h22);
    wr(0, 3);
    idle(2);
    rd(1, d); check("R6 low zero wins", d, 0);
    rd(2, d); check("R6 high zero wins", d, 0);
    // zero write edge Ec; this capture lands on Ec+5 and sees 4
    wr(0, 2);
    idle(2);
    rd(1, d); check("R6 counter restarted", d, 4);
  endtask

  task automatic t_prio();
    int d;
    wr(0, 1);
    idle(5);
    wr(0, 2);
    wr(1, 8'hAA);
    idle(1);
    rd(1, d); check("R8 capture beats low write", d, 5);
    wr(0, 1);
    wr(2, 8'h33);
    idle(1);
    rd(2, d); check("R8 zero beats high write", d, 0);
    wr(2, 8'h34);
    rd(2, d); check("R7 high write after command", d, 8'h34);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_selfclear();
    t_capture();
    t_carry();
    t_direct();
    t_zero();
    t_both();
    t_prio();
    t_wrap();
    finish_run();
  end
endmodule